// File: doc/BRIEF.md
# Multi-bit ECC error application engine

This block sits behind a four-error-correcting syndrome and locator unit and applies its results to a 512-byte sector buffer. After a sector has been read, the engine is started with the ten stored check bytes and the four syndrome words. It first screens out two cases that need no correction: a page whose check bytes are all 0xFF is treated as erased, and a zero syndrome means nothing was detected. In both cases the engine finishes at once and reports zero fixes.

Otherwise the engine pulses a launch strobe to the locator. It then runs a two-phase wait. A locator that has only just been launched can still show a "complete" code left over from the previous job, so the engine first waits for a busy code and only after that waits for a terminal code. A terminal code reports a clean result, a failure with five or more errors, or ready error locations. When locations are ready, the engine reads up to four address/value entries from two packed register pairs. It translates each address from its end-relative form into a buffer index. Indices that land in the check bytes are dropped. Each remaining byte gets one read-modify-write that XORs in the error value.

A cycle budget guards both wait phases. When the budget runs out, the job is aborted and flagged as failed. Each job ends with a one-cycle done pulse, together with the number of bytes fixed and a failure flag.

Top module: `ecc_fix_engine`

## Requirements
- R1: When start is sampled in idle and all ten check-byte inputs equal 0xFF, the engine raises done on the next cycle with fix_count 0 and uncorrectable 0. It issues no loc_go and no buffer access. This holds whatever the syndrome is.
- R2: When start is sampled in idle, the check bytes are not all 0xFF and all four syndrome words are zero, the engine behaves as in R1: done follows with zero fixes and no locator launch.
- R3: Otherwise loc_go is high for exactly one cycle. Codes below 4 on loc_state are then ignored until a code of 4 or more has been seen. Only after that is a code below 4 taken as terminal.
- R4: loc_state codes are decoded as follows. Terminal code 0 ends the job with fix_count 0 and uncorrectable 0. Terminal code 1 ends it with uncorrectable 1, fix_count 0 and no buffer write. Codes 2 and 3 start the correction phase.
- R5: In the correction phase the error count is loc_nerr + 1, with loc_nerr taken when the terminal code is seen. Entries are taken in this order: entry 0 from bits 15:0 of err_addr0/err_val0, entry 1 from bits 31:16 of the same pair, entry 2 from bits 15:0 of err_addr1/err_val1, and entry 3 from bits 31:16 of that pair.
- R6: An entry's raw address is the low 10 bits of its 16-bit half, and its buffer index is 519 minus the raw address. An entry whose index falls outside 0..511 causes no buffer access and is not counted.
- R7: Each entry with a valid index produces one buffer read at that index. On the next cycle a write to the same index follows, with data equal to the read byte XOR the low 8 bits of the value half. Each such write adds one to fix_count.
- R8: If TIMEOUT_CYCLES cycles pass in the wait phases without a terminal code, the job ends with timed_out 1, uncorrectable 1 and fix_count 0. With the launch cycle, done then rises TIMEOUT_CYCLES+2 cycles after the start cycle.
- R9: done is a single-cycle pulse. fix_count, uncorrectable and timed_out keep their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (accepted in idle only) |
| ecc_code | input | 80 | Ten stored check bytes, byte k at bits 8k+7:8k |
| syndrome | input | 128 | Four syndrome words, word w at bits 32w+31:32w |
| loc_state | input | 4 | Locator state code |
| loc_nerr | input | 2 | Locator error count minus one |
| err_addr0 | input | 32 | Packed raw addresses of entries 0 (low) and 1 (high) |
| err_addr1 | input | 32 | Packed raw addresses of entries 2 (low) and 3 (high) |
| err_val0 | input | 32 | Packed error values of entries 0 (low) and 1 (high) |
| err_val1 | input | 32 | Packed error values of entries 2 (low) and 3 (high) |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after buf_rd_en |
| loc_go | output | 1 | One-cycle locator launch strobe |
| buf_addr | output | 9 | Buffer byte index |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Job-complete pulse |
| fix_count | output | 3 | Bytes corrected in the last job |
| uncorrectable | output | 1 | Last job failed (too many errors or timeout) |
| timed_out | output | 1 | Last job was aborted by the wait budget |

## Verification
The bench builds the engine with the default 512-byte sector and a bias of 7, so the real index translation is exercised. Raw addresses 0..7 and those above 519 hit the skip path, and indices 0 and 511 test the two buffer edges. TIMEOUT_CYCLES is lowered to 40. This lets both hang cases finish quickly: a locator stuck on a stale "complete" code, and one stuck busy. The exact cycle of the done pulse can then be checked against the budget. A locator model in the bench shows stale codes and zeroed location registers before its busy phase. An engine that accepted the false completion would therefore fix nothing.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

    localparam int LOC_W      = 4;
    localparam int NERR_W     = 2;
    localparam int MAX_ERRS   = 4;
    localparam int CNT_W      = 3;
    localparam int REG_W      = 32;
    localparam int HALF_W     = 16;
    localparam int VAL_W      = 8;

    localparam logic [LOC_W-1:0] LOC_NO_ERROR  = 4'd0;
    localparam logic [LOC_W-1:0] LOC_TOO_MANY  = 4'd1;
    localparam logic [LOC_W-1:0] LOC_BUSY_MIN  = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT_BUSY,
        ST_WAIT_DONE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } fix_state_e;

    typedef struct packed {
        fix_state_e        st;
        logic [NERR_W-1:0] idx;
        logic [NERR_W-1:0] last;
        logic [CNT_W-1:0]  count;
        logic              fail;
        logic              tmo;
    } fix_regs_t;

endpackage

// File: rtl/ecc_fix_screen.sv
module ecc_fix_screen #(
    parameter int ECC_BYTES = 10,
    parameter int SYN_WORDS = 4,
    parameter int SYN_BITS  = 32
) (
    input  logic [ECC_BYTES*8-1:0]        ecc_code,
    input  logic [SYN_WORDS*SYN_BITS-1:0] syndrome,
    output logic                          erased,
    output logic                          clean
);

    logic [ECC_BYTES-1:0] byte_blank;
    logic [SYN_WORDS-1:0] word_zero;

    // one comparator per stored check byte
    for (genvar b = 0; b < ECC_BYTES; b++) begin : g_byte
        assign byte_blank[b] = (ecc_code[b*8 +: 8] == 8'hFF);
    end

    // one zero detector per syndrome word
    for (genvar w = 0; w < SYN_WORDS; w++) begin : g_word
        assign word_zero[w] = (syndrome[w*SYN_BITS +: SYN_BITS] == '0);
    end

    assign erased = &byte_blank;
    assign clean  = &word_zero;

endmodule

// File: rtl/ecc_fix_slot.sv
module ecc_fix_slot
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_BIAS    = 7,
    parameter int RAW_BITS     = 10,
    localparam int AW          = $clog2(SECTOR_BYTES)
) (
    input  logic [NERR_W-1:0] idx,
    input  logic [REG_W-1:0]  addr_pair0,
    input  logic [REG_W-1:0]  addr_pair1,
    input  logic [REG_W-1:0]  val_pair0,
    input  logic [REG_W-1:0]  val_pair1,
    output logic [AW-1:0]     index,
    output logic [VAL_W-1:0]  value,
    output logic              in_range
);

    localparam int TOP_INDEX = SECTOR_BYTES + ADDR_BIAS;

    logic [REG_W-1:0]    addr_pair;
    logic [REG_W-1:0]    val_pair;
    logic [HALF_W-1:0]   addr_half;
    logic [HALF_W-1:0]   val_half;
    logic [RAW_BITS-1:0] raw;
    int                  pos;
    logic                unused_bits;

    // entries 0,1 live in pair 0; entries 2,3 in pair 1; odd entries high half
    always_comb begin
        addr_pair = idx[1] ? addr_pair1 : addr_pair0;
        val_pair  = idx[1] ? val_pair1  : val_pair0;
        addr_half = idx[0] ? addr_pair[REG_W-1:HALF_W] : addr_pair[HALF_W-1:0];
        val_half  = idx[0] ? val_pair[REG_W-1:HALF_W]  : val_pair[HALF_W-1:0];
        raw       = addr_half[RAW_BITS-1:0];
        value     = val_half[VAL_W-1:0];
    end

    // end-relative address to buffer index; negative or past-end lands outside
    always_comb begin
        pos      = TOP_INDEX - int'(raw);
        in_range = (pos >= 0) && (pos < SECTOR_BYTES);
        index    = AW'(pos);
    end

    assign unused_bits = ^{addr_half[HALF_W-1:RAW_BITS], val_half[HALF_W-1:VAL_W]};

endmodule

// File: rtl/ecc_fix_timer.sv
module ecc_fix_timer #(
    parameter int LIMIT = 4096,
    localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ecc_fix_engine.sv
module ecc_fix_engine
    import ecc_fix_pkg::*;
#(
    parameter int SECTOR_BYTES   = 512,
    parameter int ADDR_BIAS      = 7,
    parameter int RAW_BITS       = 10,
    parameter int ECC_BYTES      = 10,
    parameter int SYN_WORDS      = 4,
    parameter int SYN_BITS       = 32,
    parameter int TIMEOUT_CYCLES = 4096,
    localparam int AW            = $clog2(SECTOR_BYTES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ECC_BYTES*8-1:0]        ecc_code,
    input  logic [SYN_WORDS*SYN_BITS-1:0] syndrome,
    input  logic [LOC_W-1:0]              loc_state,
    input  logic [NERR_W-1:0]             loc_nerr,
    input  logic [REG_W-1:0]              err_addr0,
    input  logic [REG_W-1:0]              err_addr1,
    input  logic [REG_W-1:0]              err_val0,
    input  logic [REG_W-1:0]              err_val1,
    input  logic [VAL_W-1:0]              buf_rdata,
    output logic                          loc_go,
    output logic [AW-1:0]                 buf_addr,
    output logic                          buf_rd_en,
    output logic                          buf_wr_en,
    output logic [VAL_W-1:0]              buf_wdata,
    output logic                          done,
    output logic [CNT_W-1:0]              fix_count,
    output logic                          uncorrectable,
    output logic                          timed_out
);

    fix_regs_t         r_d, r_q;
    logic              erased, clean;
    logic [AW-1:0]     slot_index;
    logic [VAL_W-1:0]  slot_value;
    logic              slot_ok;
    logic              tmr_clear, tmr_run, tmr_expired;

    ecc_fix_screen #(
        .ECC_BYTES (ECC_BYTES),
        .SYN_WORDS (SYN_WORDS),
        .SYN_BITS  (SYN_BITS)
    ) u_screen (
        .ecc_code (ecc_code),
        .syndrome (syndrome),
        .erased   (erased),
        .clean    (clean)
    );

    ecc_fix_slot #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .ADDR_BIAS    (ADDR_BIAS),
        .RAW_BITS     (RAW_BITS)
    ) u_slot (
        .idx        (r_q.idx),
        .addr_pair0 (err_addr0),
        .addr_pair1 (err_addr1),
        .val_pair0  (err_val0),
        .val_pair1  (err_val1),
        .index      (slot_index),
        .value      (slot_value),
        .in_range   (slot_ok)
    );

    ecc_fix_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

    // step to the next entry or close the job after the last one
    function automatic fix_regs_t advance(input fix_regs_t cur);
        fix_regs_t nxt;
        nxt = cur;
        if (cur.idx == cur.last) begin
            nxt.st = ST_FINISH;
        end else begin
            nxt.idx = cur.idx + 1'b1;
            nxt.st  = ST_READ;
        end
        return nxt;
    endfunction

    always_comb begin
        r_d       = r_q;
        loc_go    = 1'b0;
        buf_rd_en = 1'b0;
        buf_wr_en = 1'b0;
        tmr_clear = 1'b0;
        tmr_run   = 1'b0;
        buf_addr  = slot_index;
        buf_wdata = buf_rdata ^ slot_value;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.count = '0;
                    r_d.fail  = 1'b0;
                    r_d.tmo   = 1'b0;
                    r_d.idx   = '0;
                    r_d.last  = '0;
                    if (erased || clean) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.st = ST_LAUNCH;
                    end
                end
            end

            ST_LAUNCH: begin
                loc_go    = 1'b1;
                tmr_clear = 1'b1;
                r_d.st    = ST_WAIT_BUSY;
            end

            // phase one: a stale "complete" code may still be showing
            ST_WAIT_BUSY: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    r_d.fail = 1'b1;
                    r_d.tmo  = 1'b1;
                    r_d.st   = ST_FINISH;
                end else if (loc_state >= LOC_BUSY_MIN) begin
                    r_d.st = ST_WAIT_DONE;
                end
            end

            // phase two: the first code below the busy range is the verdict
            ST_WAIT_DONE: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    r_d.fail = 1'b1;
                    r_d.tmo  = 1'b1;
                    r_d.st   = ST_FINISH;
                end else if (loc_state == LOC_NO_ERROR) begin
                    r_d.st = ST_FINISH;
                end else if (loc_state == LOC_TOO_MANY) begin
                    r_d.fail = 1'b1;
                    r_d.st   = ST_FINISH;
                end else if (loc_state < LOC_BUSY_MIN) begin
                    r_d.last = loc_nerr;
                    r_d.idx  = '0;
                    r_d.st   = ST_READ;
                end
            end

            ST_READ: begin
                if (slot_ok) begin
                    buf_rd_en = 1'b1;
                    r_d.st    = ST_WRITE;
                end else begin
                    r_d = advance(r_q);
                end
            end

            ST_WRITE: begin
                buf_wr_en = 1'b1;
                r_d       = advance(r_q);
                r_d.count = r_q.count + 1'b1;
            end

            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, last: '0, count: '0, fail: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done          = (r_q.st == ST_FINISH);
    assign fix_count     = r_q.count;
    assign uncorrectable = r_q.fail;
    assign timed_out     = r_q.tmo;

endmodule

// File: rtl/ecc_fix_engine_chk.sv
module ecc_fix_engine_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          loc_go,
    input logic [AW-1:0] buf_addr,
    input logic          buf_rd_en,
    input logic          buf_wr_en,
    input logic          done,
    input logic [2:0]    fix_count,
    input logic          uncorrectable,
    input logic          timed_out
);

    p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_go |=> !loc_go);

    p_fail_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (fix_count == 3'd0));

    p_count_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fix_count <= 3'd4));

    p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && (buf_addr == $past(buf_addr))));

    p_rw_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

    p_timeout_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timed_out) |-> uncorrectable);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_access_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(buf_rd_en || buf_wr_en || loc_go));

endmodule

bind ecc_fix_engine ecc_fix_engine_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .loc_go        (loc_go),
    .buf_addr      (buf_addr),
    .buf_rd_en     (buf_rd_en),
    .buf_wr_en     (buf_wr_en),
    .done          (done),
    .fix_count     (fix_count),
    .uncorrectable (uncorrectable),
    .timed_out     (timed_out)
);

// File: tb/tb_ecc_fix_engine.sv
`timescale 1ns/1ps
module tb_ecc_fix_engine;

    localparam int SECTOR  = 512;
    localparam int TMO     = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [79:0]  ecc_in = '0;
    logic [127:0] syn_in = '0;
    logic [3:0]   loc_state = 4'd3;
    logic [1:0]   loc_nerr = 2'd0;
    logic [31:0]  a0 = '0, a1 = '0, v0 = '0, v1 = '0;
    logic [7:0]   buf_rdata;
    logic         loc_go;
    logic [8:0]   buf_addr;
    logic         buf_rd_en, buf_wr_en;
    logic [7:0]   buf_wdata;
    logic         done;
    logic [2:0]   fix_count;
    logic         uncorrectable, timed_out;

    always #4 clk = ~clk;

    ecc_fix_engine #(.TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_code(ecc_in), .syndrome(syn_in),
        .loc_state(loc_state), .loc_nerr(loc_nerr), .err_addr0(a0), .err_addr1(a1),
        .err_val0(v0), .err_val1(v1), .buf_rdata(buf_rdata), .loc_go(loc_go),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
        .buf_wdata(buf_wdata), .done(done), .fix_count(fix_count),
        .uncorrectable(uncorrectable), .timed_out(timed_out)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- buffer model ----------------
    logic [7:0] mem [SECTOR];
    logic       load_req = 1'b0;
    int         seed = 0;
    int         rd_cnt = 0;
    int         wr_cnt = 0;

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 37 + s * 11) ^ (i >> 3));
    endfunction

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < SECTOR; i++) mem[i] <= pat(i, seed);
        end else begin
            if (buf_wr_en) begin
                mem[buf_addr] <= buf_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (buf_rd_en) begin
                buf_rdata <= mem[buf_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // ---------------- locator model ----------------
    int          m_pre = 0, m_busy = 1, m_hang = 0;
    logic [3:0]  m_final = 4'd2;
    logic [1:0]  m_nerr = 2'd0;
    logic [31:0] m_a0 = '0, m_a1 = '0, m_v0 = '0, m_v1 = '0;
    int          m_cnt = 0;
    bit          m_run = 1'b0;
    int          go_cnt = 0;

    always @(negedge clk) begin
        if (loc_go) begin
            go_cnt <= go_cnt + 1;
            m_cnt  = 0;
            m_run  = 1'b1;
            loc_state <= 4'd3;
            loc_nerr  <= 2'd0;
            a0 <= '0; a1 <= '0; v0 <= '0; v1 <= '0;
        end else if (m_run) begin
            m_cnt++;
            if (m_hang == 1) loc_state <= 4'd3;
            else if (m_hang == 2) loc_state <= 4'd9;
            else if (m_cnt <= m_pre) loc_state <= 4'd3;
            else if (m_cnt <= m_pre + m_busy) loc_state <= 4'd9;
            else begin
                loc_state <= m_final;
                loc_nerr  <= m_nerr;
                a0 <= m_a0; a1 <= m_a1; v0 <= m_v0; v1 <= m_v1;
                m_run = 1'b0;
            end
        end
    end

    // raw address half with junk above the 10-bit field
    function automatic logic [15:0] raw_half(input int raw);
        return {6'b101101, 10'(raw)};
    endfunction

    function automatic logic [15:0] idx_half(input int index);
        return raw_half(519 - index);
    endfunction

    function automatic logic [15:0] val_half(input logic [7:0] v);
        return {8'hC3, v};
    endfunction

    // ---------------- job helpers ----------------
    int         cycles;
    int         exp_n;
    int         exp_ix [4];
    logic [7:0] exp_v  [4];

    task automatic load_buffer(input int s);
        @(negedge clk);
        seed = s;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic run_job(input string req, input logic [79:0] ecc, input logic [127:0] syn);
        logic [2:0] c;
        logic       u, t;
        @(negedge clk);
        ecc_in = ecc;
        syn_in = syn;
        start  = 1'b1;
        cycles = 0;
        do begin
            @(posedge clk);
            #1;
            start = 1'b0;
            cycles++;
        end while (!done && cycles < 400);
        check({req, " done seen"}, 32'(done), 32'd1);
        c = fix_count; u = uncorrectable; t = timed_out;
        @(posedge clk);
        #1;
        check("R9 done single pulse", 32'(done), 32'd0);
        check("R9 results held", {29'd0, c}, {29'd0, fix_count});
        check("R9 flags held", {30'd0, u, t}, {30'd0, uncorrectable, timed_out});
    endtask

    task automatic verify_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < SECTOR; i++) begin
            logic [7:0] e;
            e = pat(i, seed);
            for (int k = 0; k < exp_n; k++) if (exp_ix[k] == i) e = e ^ exp_v[k];
            if (mem[i] !== e) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check({req, " buffer mismatches"}, 32'(bad), 32'd0);
        if (first >= 0) $display("  first mismatch at index %0d", first);
    endtask

    localparam logic [79:0]  ECC_USED = 80'h0123_4567_89AB_CDEF_F0E1;
    localparam logic [127:0] SYN_HIT  = 128'h0000_0000_0000_0000_0000_0000_0000_0100;

    task automatic set_loc(input int pre, input int busy, input int hang, input logic [3:0] fin,
                           input logic [1:0] n, input logic [31:0] pa0, input logic [31:0] pa1,
                           input logic [31:0] pv0, input logic [31:0] pv1);
        m_pre = pre; m_busy = busy; m_hang = hang; m_final = fin; m_nerr = n;
        m_a0 = pa0; m_a1 = pa1; m_v0 = pv0; m_v1 = pv1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R9 reset done", 32'(done), 32'd0);
        check("R9 reset fix_count", 32'(fix_count), 32'd0);
        check("R4 reset uncorrectable", 32'(uncorrectable), 32'd0);
        check("R3 reset loc_go", 32'(loc_go), 32'd0);
        check("R7 reset buffer strobes", {30'd0, buf_rd_en, buf_wr_en}, 32'd0);
    endtask

    task automatic t_erased();
        int g = go_cnt; int w = wr_cnt; int r = rd_cnt;
        load_buffer(1);
        exp_n = 0;
        run_job("R1 erased", {80{1'b1}}, SYN_HIT);
        check("R1 erased latency", 32'(cycles), 32'd1);
        check("R1 erased count", 32'(fix_count), 32'd0);
        check("R1 erased no fail", 32'(uncorrectable), 32'd0);
        check("R1 erased no launch", 32'(go_cnt - g), 32'd0);
        check("R1 erased no access", 32'((wr_cnt - w) + (rd_cnt - r)), 32'd0);
        verify_mem("R1");
    endtask

    task automatic t_clean();
        int g = go_cnt;
        load_buffer(2);
        exp_n = 0;
        run_job("R2 clean", ECC_USED, '0);
        check("R2 clean latency", 32'(cycles), 32'd1);
        check("R2 clean count", 32'(fix_count), 32'd0);
        check("R2 clean no launch", 32'(go_cnt - g), 32'd0);
        verify_mem("R2");
    endtask

    task automatic t_single();
        int g = go_cnt;
        load_buffer(3);
        set_loc(0, 2, 0, 4'd2, 2'd0, {16'h0, idx_half(100)}, '0, {16'h0, val_half(8'h5A)}, '0);
        exp_n = 1; exp_ix[0] = 100; exp_v[0] = 8'h5A;
        run_job("R7 single", ECC_USED, SYN_HIT);
        check("R3 single launch once", 32'(go_cnt - g), 32'd1);
        check("R7 single count", 32'(fix_count), 32'd1);
        check("R4 single no fail", 32'(uncorrectable), 32'd0);
        verify_mem("R7");
    endtask

    task automatic t_four();
        load_buffer(4);
        set_loc(1, 3, 0, 4'd3, 2'd3,
                {idx_half(511), idx_half(0)}, {idx_half(7), idx_half(250)},
                {val_half(8'h81), val_half(8'h01)}, {val_half(8'hFF), val_half(8'h3C)});
        exp_n = 4;
        exp_ix[0] = 0;   exp_v[0] = 8'h01;
        exp_ix[1] = 511; exp_v[1] = 8'h81;
        exp_ix[2] = 250; exp_v[2] = 8'h3C;
        exp_ix[3] = 7;   exp_v[3] = 8'hFF;
        run_job("R5 four", ECC_USED, SYN_HIT);
        check("R5 four count", 32'(fix_count), 32'd4);
        verify_mem("R5 slot order and edges");
    endtask

    task automatic t_skip();
        int w = wr_cnt;
        load_buffer(5);
        // raw 3 -> index 516 (check bytes), raw 900 -> past range, raw 419 -> index 100
        set_loc(0, 1, 0, 4'd2, 2'd2,
                {raw_half(900), raw_half(3)}, {16'h0, idx_half(100)},
                {val_half(8'h11), val_half(8'h22)}, {16'h0, val_half(8'h44)});
        exp_n = 1; exp_ix[0] = 100; exp_v[0] = 8'h44;
        run_job("R6 skip", ECC_USED, SYN_HIT);
        check("R6 skip count", 32'(fix_count), 32'd1);
        check("R6 skip writes", 32'(wr_cnt - w), 32'd1);
        verify_mem("R6");
    endtask

    task automatic t_too_many();
        int w = wr_cnt;
        load_buffer(6);
        set_loc(0, 2, 0, 4'd1, 2'd3, {idx_half(5), idx_half(6)}, '0, 32'hFFFF_FFFF, '0);
        exp_n = 0;
        run_job("R4 too many", ECC_USED, SYN_HIT);
        check("R4 too many flag", 32'(uncorrectable), 32'd1);
        check("R4 too many count", 32'(fix_count), 32'd0);
        check("R4 too many no write", 32'(wr_cnt - w), 32'd0);
        check("R8 too many not timeout", 32'(timed_out), 32'd0);
        verify_mem("R4");
    endtask

    task automatic t_no_error();
        load_buffer(7);
        set_loc(0, 2, 0, 4'd0, 2'd1, {idx_half(5), idx_half(6)}, '0, 32'hFFFF_FFFF, '0);
        exp_n = 0;
        run_job("R4 code0", ECC_USED, SYN_HIT);
        check("R4 code0 no fail", 32'(uncorrectable), 32'd0);
        check("R4 code0 count", 32'(fix_count), 32'd0);
        verify_mem("R4 code0");
    endtask

    task automatic t_false_done();
        load_buffer(8);
        set_loc(6, 4, 0, 4'd2, 2'd1, {idx_half(300), idx_half(20)}, '0,
                {val_half(8'hA5), val_half(8'h0F)}, '0);
        exp_n = 2; exp_ix[0] = 20; exp_v[0] = 8'h0F; exp_ix[1] = 300; exp_v[1] = 8'hA5;
        run_job("R3 stale complete", ECC_USED, SYN_HIT);
        check("R3 stale complete count", 32'(fix_count), 32'd2);
        verify_mem("R3");
    endtask

    task automatic t_timeout(input int hang);
        int w = wr_cnt;
        load_buffer(9);
        set_loc(0, 1, hang, 4'd2, 2'd0, {16'h0, idx_half(1)}, '0, {16'h0, val_half(8'h77)}, '0);
        exp_n = 0;
        run_job("R8 timeout", ECC_USED, SYN_HIT);
        check("R8 timeout latency", 32'(cycles), 32'(TMO + 2));
        check("R8 timeout flag", 32'(timed_out), 32'd1);
        check("R8 timeout fail", 32'(uncorrectable), 32'd1);
        check("R8 timeout count", 32'(fix_count), 32'd0);
        check("R8 timeout no write", 32'(wr_cnt - w), 32'd0);
        // release the model before the next job
        m_hang = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_restart_clears();
        load_buffer(10);
        exp_n = 0;
        run_job("R9 restart", ECC_USED, '0);
        check("R9 restart clears timeout", 32'(timed_out), 32'd0);
        check("R9 restart clears fail", 32'(uncorrectable), 32'd0);
    endtask

    // ---------------- watchdog and main ----------------
    bit finished = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_erased();
        t_clean();
        t_single();
        t_four();
        t_skip();
        t_too_many();
        t_no_error();
        t_false_done();
        t_timeout(1);
        t_timeout(2);
        t_restart_clears();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule